// File: doc/BRIEF.md
# Stereo Soft-Ramp Attenuation Controller

This block works out, for each channel of a stereo audio path, the attenuation that the downstream gain stage should apply right now. Software writes a 7-bit attenuation code per channel in whole decibels, a mute bit per channel, a two-bit transition policy, a link bit and an auto-mute enable. The block turns these into a target level in eighth-decibel units. It then moves each channel's live level toward that target under the chosen policy. The level is updated only on a sample strobe, which fires once per left/right clock period.

Each channel has its own monitor on the incoming signed samples. The monitor finds zero crossings, which are used by the deferred and stepped policies. It also counts runs of silent samples for auto-mute. The block reports each channel's live level, a muted flag per channel, and one external mute-control signal for an analog mute circuit.

Top module: `vr_volume_ctrl`

## Requirements
- R1: After reset both levels are 0 (0 dB), both muted flags are low and the mute-control output is low.
- R2: A code N from 0 to 94 gives a target level of 8*N eighth-dB units.
- R3: With transition mode 2'b00, the level jumps straight to a new target on the first sample strobe after the change. Without a strobe the level never changes.
- R4: With mode 2'b01, a pending change is applied whole on a strobe whose sample is a zero crossing for that channel. A zero crossing means the sign bit (bit 23) differs from the previous sample's sign bit, or the sample is exactly zero. Each channel is judged on its own samples only.
- R5: In modes 2'b01 and 2'b11, if 1023 strobes pass without a zero crossing, the 1024th strobe applies the pending move anyway. The count restarts when a new target is accepted and after every move.
- R6: With mode 2'b10, the level moves one eighth-dB unit toward the target on every strobe.
- R7: With mode 2'b11, the level moves one eighth-dB unit toward the target, but only on strobes that carry a zero crossing (or that hit the R5 timeout).
- R8: A set mute bit, or a code above 94, makes the target 760 (95 dB). A channel's muted flag is high exactly when its level equals 760. Moves toward 760 follow the active mode.
- R9: With auto-mute enabled, a channel's target becomes 760 after 8192 consecutive samples that are all zeros or all ones. A single sample of any other value releases it, and the return follows the active mode.
- R10: With the link bit set, channel B uses channel A's code and its own code has no effect.
- R11: The mute-control output is high only while both channels are muted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| att_code_a | input | 7 | Channel A attenuation code, 1 dB units |
| att_code_b | input | 7 | Channel B attenuation code, 1 dB units |
| mute_a | input | 1 | Channel A mute request |
| mute_b | input | 1 | Channel B mute request |
| xfer_mode | input | 2 | Transition policy: 00 step, 01 zero-cross, 10 ramp, 11 ramp on zero-cross |
| link_ab | input | 1 | Channel B follows channel A's code |
| amute_en | input | 1 | Enables silence-triggered mute |
| smp_valid | input | 1 | One-cycle sample strobe, once per left/right period |
| smp_a | input | 24 | Channel A sample, two's complement |
| smp_b | input | 24 | Channel B sample, two's complement |
| level_a | output | 10 | Channel A live attenuation, eighth-dB units |
| level_b | output | 10 | Channel B live attenuation, eighth-dB units |
| muted_a | output | 1 | Channel A is at the mute level |
| muted_b | output | 1 | Channel B is at the mute level |
| mute_ctl | output | 1 | External mute control, both channels muted |

## Verification
The bench runs a reference model that predicts both levels after every strobe, and each strobe result is compared in turn. It targets the following corner cases:

- A zero-cross change where only one channel sees a sign flip. A design sharing detection across channels would move both.
- An exactly-zero sample used as a crossing.
- A run of same-sign samples that must hold a change for exactly 1023 strobes before forcing it on the 1024th. An off-by-one timer would show up as an early or late jump.
- Code 94 against codes above 94, and the mute-control output with one channel versus both channels at mute.
- Auto-mute built from runs of zeros and of minus one, followed by a release that must ramp back one step per strobe. A design that snapped back, or kept the count running across a non-silent sample, would diverge from the model.

// File: rtl/vr_pkg.sv
package vr_pkg;

    typedef enum logic [1:0] {
        XM_STEP    = 2'b00,
        XM_ZC      = 2'b01,
        XM_RAMP    = 2'b10,
        XM_RAMP_ZC = 2'b11
    } xfer_mode_e;

endpackage

// File: rtl/vr_sample_mon.sv
module vr_sample_mon #(
    parameter int DW      = 24,
    parameter int RUN_LEN = 8192
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          valid,
    input  logic [DW-1:0] sample,
    output logic          zc,
    output logic          run_hit
);
    localparam int RW = $clog2(RUN_LEN + 1);

    typedef struct packed {
        logic          sign;
        logic [RW-1:0] run;
    } mon_t;

    mon_t s_d, s_q;
    logic all_zero, all_one;

    always_comb begin
        all_zero = (sample == '0);
        all_one  = (sample == '1);
        zc       = all_zero || (sample[DW-1] != s_q.sign);
        run_hit  = (s_q.run == RW'(RUN_LEN));
        s_d      = s_q;
        if (valid) begin
            s_d.sign = sample[DW-1];
            if (all_zero || all_one) begin
                if (!run_hit) begin
                    s_d.run = s_q.run + 1'b1;
                end
            end else begin
                s_d.run = '0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

endmodule

// File: rtl/vr_target.sv
module vr_target #(
    parameter int CODE_W    = 7,
    parameter int FRAC      = 3,
    parameter int MAX_CODE  = 94,
    parameter int MUTE_CODE = 95
) (
    input  logic [CODE_W-1:0]      code,
    input  logic                   force_mute,
    output logic [CODE_W+FRAC-1:0] target
);
    localparam int LVL_W    = CODE_W + FRAC;
    localparam int MUTE_LVL = MUTE_CODE * (2 ** FRAC);

    always_comb begin
        if (force_mute || (code > CODE_W'(MAX_CODE))) begin
            target = LVL_W'(MUTE_LVL);
        end else begin
            target = {code, {FRAC{1'b0}}};
        end
    end

endmodule

// File: rtl/vr_level_track.sv
module vr_level_track
    import vr_pkg::*;
#(
    parameter int LVL_W   = 10,
    parameter int TIMEOUT = 1024
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             valid,
    input  xfer_mode_e       mode,
    input  logic [LVL_W-1:0] target,
    input  logic             zc,
    output logic [LVL_W-1:0] level
);
    localparam int TW = $clog2(TIMEOUT);

    typedef struct packed {
        logic [LVL_W-1:0] tgt;
        logic [LVL_W-1:0] cur;
        logic [TW-1:0]    tmr;
    } trk_t;

    trk_t s_d, s_q;
    logic expired, go, stepped;

    always_comb begin
        s_d     = s_q;
        expired = (s_q.tmr == TW'(TIMEOUT - 1));
        stepped = (mode == XM_RAMP) || (mode == XM_RAMP_ZC);
        go      = 1'b1;
        if ((mode == XM_ZC) || (mode == XM_RAMP_ZC)) begin
            go = zc || expired;
        end
        if (target != s_q.tgt) begin
            s_d.tgt = target;
            s_d.tmr = '0;
        end else if (valid && (s_q.cur != s_q.tgt)) begin
            if (go) begin
                s_d.tmr = '0;
                if (stepped) begin
                    s_d.cur = (s_q.cur < s_q.tgt) ? s_q.cur + 1'b1 : s_q.cur - 1'b1;
                end else begin
                    s_d.cur = s_q.tgt;
                end
            end else begin
                s_d.tmr = s_q.tmr + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign level = s_q.cur;

endmodule

// File: rtl/vr_volume_ctrl.sv
module vr_volume_ctrl
    import vr_pkg::*;
#(
    parameter int CODE_W    = 7,
    parameter int FRAC      = 3,
    parameter int DW        = 24,
    parameter int MAX_CODE  = 94,
    parameter int MUTE_CODE = 95,
    parameter int TIMEOUT   = 1024,
    parameter int RUN_LEN   = 8192
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [CODE_W-1:0]      att_code_a,
    input  logic [CODE_W-1:0]      att_code_b,
    input  logic                   mute_a,
    input  logic                   mute_b,
    input  logic [1:0]             xfer_mode,
    input  logic                   link_ab,
    input  logic                   amute_en,
    input  logic                   smp_valid,
    input  logic [DW-1:0]          smp_a,
    input  logic [DW-1:0]          smp_b,
    output logic [CODE_W+FRAC-1:0] level_a,
    output logic [CODE_W+FRAC-1:0] level_b,
    output logic                   muted_a,
    output logic                   muted_b,
    output logic                   mute_ctl
);
    localparam int LVL_W    = CODE_W + FRAC;
    localparam int NCH      = 2;
    localparam int MUTE_LVL = MUTE_CODE * (2 ** FRAC);

    logic [CODE_W-1:0] code_sel [NCH];
    logic [DW-1:0]     smp      [NCH];
    logic [LVL_W-1:0]  target   [NCH];
    logic [LVL_W-1:0]  level    [NCH];
    logic [NCH-1:0]    mute_bit, zc, run_hit, force_mute, muted;
    xfer_mode_e        mode;

    assign mode        = xfer_mode_e'(xfer_mode);
    assign code_sel[0] = att_code_a;
    assign code_sel[1] = link_ab ? att_code_a : att_code_b;
    assign smp[0]      = smp_a;
    assign smp[1]      = smp_b;
    assign mute_bit    = {mute_b, mute_a};

    for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
        vr_sample_mon #(
            .DW      (DW),
            .RUN_LEN (RUN_LEN)
        ) i_mon (
            .clk     (clk),
            .rst_n   (rst_n),
            .valid   (smp_valid),
            .sample  (smp[ch]),
            .zc      (zc[ch]),
            .run_hit (run_hit[ch])
        );

        assign force_mute[ch] = mute_bit[ch] | (amute_en & run_hit[ch]);

        vr_target #(
            .CODE_W    (CODE_W),
            .FRAC      (FRAC),
            .MAX_CODE  (MAX_CODE),
            .MUTE_CODE (MUTE_CODE)
        ) i_tgt (
            .code       (code_sel[ch]),
            .force_mute (force_mute[ch]),
            .target     (target[ch])
        );

        vr_level_track #(
            .LVL_W   (LVL_W),
            .TIMEOUT (TIMEOUT)
        ) i_trk (
            .clk    (clk),
            .rst_n  (rst_n),
            .valid  (smp_valid),
            .mode   (mode),
            .target (target[ch]),
            .zc     (zc[ch]),
            .level  (level[ch])
        );

        assign muted[ch] = (level[ch] == LVL_W'(MUTE_LVL));
    end

    assign level_a  = level[0];
    assign level_b  = level[1];
    assign muted_a  = muted[0];
    assign muted_b  = muted[1];
    assign mute_ctl = &muted;

endmodule

// File: rtl/vr_volume_ctrl_chk.sv
module vr_volume_ctrl_chk #(
    parameter int LVL_W    = 10,
    parameter int MUTE_LVL = 760
) (
    input logic             clk,
    input logic             rst_n,
    input logic             smp_valid,
    input logic [1:0]       xfer_mode,
    input logic [LVL_W-1:0] level_a,
    input logic [LVL_W-1:0] level_b,
    input logic             muted_a,
    input logic             muted_b,
    input logic             mute_ctl
);

    a_r3_hold_idle_a: assert property (@(posedge clk) disable iff (!rst_n)
        !smp_valid |=> $stable(level_a));

    a_r3_hold_idle_b: assert property (@(posedge clk) disable iff (!rst_n)
        !smp_valid |=> $stable(level_b));

    a_r6_single_step_a: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_valid && xfer_mode == 2'b10) |=>
            ((level_a == $past(level_a)) || (level_a == $past(level_a) + 1'b1) ||
             (level_a + 1'b1 == $past(level_a))));

    a_r6_single_step_b: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_valid && xfer_mode == 2'b10) |=>
            ((level_b == $past(level_b)) || (level_b == $past(level_b) + 1'b1) ||
             (level_b + 1'b1 == $past(level_b))));

    a_r8_muted_level_a: assert property (@(posedge clk) disable iff (!rst_n)
        muted_a |-> (level_a == LVL_W'(MUTE_LVL)));

    a_r8_muted_level_b: assert property (@(posedge clk) disable iff (!rst_n)
        muted_b |-> (level_b == LVL_W'(MUTE_LVL)));

    a_r8_level_ceiling: assert property (@(posedge clk) disable iff (!rst_n)
        (level_a <= LVL_W'(MUTE_LVL)) && (level_b <= LVL_W'(MUTE_LVL)));

    a_r11_mute_ctl_both: assert property (@(posedge clk) disable iff (!rst_n)
        mute_ctl |-> ((level_a == LVL_W'(MUTE_LVL)) && (level_b == LVL_W'(MUTE_LVL))));

endmodule

bind vr_volume_ctrl vr_volume_ctrl_chk i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .smp_valid (smp_valid),
    .xfer_mode (xfer_mode),
    .level_a   (level_a),
    .level_b   (level_b),
    .muted_a   (muted_a),
    .muted_b   (muted_b),
    .mute_ctl  (mute_ctl)
);

// File: tb/test_vr_volume_ctrl.sv
module test_vr_volume_ctrl;
    timeunit 1ns;
    timeprecision 1ps;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [6:0]  att_code_a = '0, att_code_b = '0;
    logic        mute_a = 1'b0, mute_b = 1'b0;
    logic [1:0]  xfer_mode = 2'b10;
    logic        link_ab = 1'b0, amute_en = 1'b0;
    logic        smp_valid = 1'b0;
    logic [23:0] smp_a = '0, smp_b = '0;
    logic [9:0]  level_a, level_b;
    logic        muted_a, muted_b, mute_ctl;

    always #2.5 clk = ~clk;

    vr_volume_ctrl i_vr_volume_ctrl (
        .clk(clk), .rst_n(rst_n), .att_code_a(att_code_a), .att_code_b(att_code_b),
        .mute_a(mute_a), .mute_b(mute_b), .xfer_mode(xfer_mode), .link_ab(link_ab),
        .amute_en(amute_en), .smp_valid(smp_valid), .smp_a(smp_a), .smp_b(smp_b),
        .level_a(level_a), .level_b(level_b), .muted_a(muted_a), .muted_b(muted_b),
        .mute_ctl(mute_ctl)
    );

    typedef struct {
        int    la;
        int    lb;
        bit    ma;
        bit    mb;
        bit    mc;
        string req;
    } exp_t;

    exp_t  sb_q[$];
    int    n_cmp = 0, n_bad = 0;
    int    m_cur[2], m_tgt[2], m_tmr[2], m_run[2];
    bit    m_prev[2];
    string req_tag = "R1";

    task automatic compare(exp_t e);
        n_cmp++;
        if (int'(level_a) != e.la || int'(level_b) != e.lb || muted_a != e.ma ||
            muted_b != e.mb || mute_ctl != e.mc) begin
            n_bad++;
            $display("FAIL %s: actual lvl=%0d/%0d muted=%0b/%0b ctl=%0b expected lvl=%0d/%0d muted=%0b/%0b ctl=%0b",
                     e.req, level_a, level_b, muted_a, muted_b, mute_ctl,
                     e.la, e.lb, e.ma, e.mb, e.mc);
        end
    endtask

    // Reference model of one channel for one strobe
    task automatic model_chan(int ch, logic [23:0] s);
        int code;
        bit mu, zc;
        int t;
        code = (ch == 0 || link_ab) ? int'(att_code_a) : int'(att_code_b);
        mu   = (ch == 0) ? mute_a : mute_b;
        t    = (mu || (amute_en && m_run[ch] >= 8192) || code > 94) ? 760 : code * 8;
        if (t != m_tgt[ch]) begin
            m_tgt[ch] = t;
            m_tmr[ch] = 0;
        end
        if (m_cur[ch] != m_tgt[ch]) begin
            zc = (s == 24'h0) || (s[23] != m_prev[ch]);
            if (!xfer_mode[0] || zc || m_tmr[ch] == 1023) begin
                m_tmr[ch] = 0;
                if (xfer_mode[1]) m_cur[ch] += (m_cur[ch] < m_tgt[ch]) ? 1 : -1;
                else              m_cur[ch] = m_tgt[ch];
            end else begin
                m_tmr[ch]++;
            end
        end
        m_prev[ch] = s[23];
        if (s == 24'h0 || s == 24'hFFFFFF) begin
            if (m_run[ch] < 8192) m_run[ch]++;
        end else begin
            m_run[ch] = 0;
        end
    endtask

    task automatic send(int sa, int sb);
        exp_t e;
        model_chan(0, sa[23:0]);
        model_chan(1, sb[23:0]);
        e.la = m_cur[0]; e.lb = m_cur[1];
        e.ma = (m_cur[0] == 760); e.mb = (m_cur[1] == 760);
        e.mc = e.ma && e.mb; e.req = req_tag;
        sb_q.push_back(e);
        smp_a = sa[23:0]; smp_b = sb[23:0]; smp_valid = 1'b1;
        @(negedge clk);
        smp_valid = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    task automatic settle();
        repeat (2) @(negedge clk);
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    // Monitor: pops one expected item per strobe
    initial begin
        exp_t e;
        forever begin
            @(posedge clk);
            if (rst_n && smp_valid) begin
                #1;
                if (sb_q.size() == 0) begin
                    n_cmp++; n_bad++;
                    $display("FAIL scoreboard: actual=strobe with no item expected=none");
                end else begin
                    e = sb_q.pop_front();
                    compare(e);
                end
            end
        end
    end

    initial begin
        repeat (190000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        summary();
        $finish;
    end

    initial begin
        exp_t e;
        for (int ch = 0; ch < 2; ch++) begin
            m_cur[ch] = 0; m_tgt[ch] = 0; m_tmr[ch] = 0; m_run[ch] = 0; m_prev[ch] = 0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        e.la = 0; e.lb = 0; e.ma = 0; e.mb = 0; e.mc = 0; e.req = "R1";
        compare(e);

        // R3 / R2: immediate step
        req_tag = "R3"; xfer_mode = 2'b00; att_code_a = 7'd10; att_code_b = 7'd3; settle();
        send(100, 100);
        send(100, 100);

        // R6: ramp one eighth-dB per strobe, up on A and down on B
        req_tag = "R6"; xfer_mode = 2'b10; att_code_a = 7'd12; att_code_b = 7'd1; settle();
        for (int i = 0; i < 20; i++) send(100, 100);

        // R4: zero-cross, per channel, zero sample counts
        req_tag = "R4"; xfer_mode = 2'b01; att_code_a = 7'd20; att_code_b = 7'd5; settle();
        for (int i = 0; i < 5; i++) send(100, 100);
        send(-5, 7);
        send(-5, 0);

        // R5: forced after timeout with no crossing
        req_tag = "R5"; att_code_a = 7'd30; settle();
        for (int i = 0; i < 1100; i++) send(-100, -100);

        // R7: ramp with each step on a zero crossing
        req_tag = "R7"; xfer_mode = 2'b11; att_code_a = 7'd32; att_code_b = 7'd7; settle();
        for (int i = 0; i < 4; i++) send(-100, -100);
        for (int i = 0; i < 20; i++) send((i % 2 == 0) ? 100 : -100, (i % 2 == 0) ? 100 : -100);

        // R10: link makes B follow A's code
        req_tag = "R10"; xfer_mode = 2'b00; link_ab = 1'b1; att_code_a = 7'd4; att_code_b = 7'd60; settle();
        send(1, 1);
        send(1, 1);

        // R8 / R11: mute bit, code 94 and code above 94
        req_tag = "R8"; link_ab = 1'b0; att_code_b = 7'd94; mute_a = 1'b1; settle();
        send(1, 1);
        req_tag = "R11"; att_code_b = 7'd100; settle();
        send(1, 1);
        send(1, 1);
        req_tag = "R8"; mute_a = 1'b0; att_code_b = 7'd0; settle();
        send(1, 1);

        // R9: auto-mute on runs of zeros and of minus one, then ramped release
        req_tag = "R9"; amute_en = 1'b1; att_code_a = 7'd0; settle();
        for (int i = 0; i < 8195; i++) send(0, -1);
        xfer_mode = 2'b10; settle();
        for (int i = 0; i < 6; i++) send(3, 3);

        while (sb_q.size() != 0) @(negedge clk);
        repeat (3) @(negedge clk);
        summary();
        $finish;
    end

endmodule